// File: doc/BRIEF.md
# ADC Sample Byte-Pair SRAM Writer

This block takes 16-bit samples from a parallel ADC and stores each one in an external SRAM whose data bus is only one byte wide. The converter signals that a sample is ready by pulling its conversion-done line low. That line has no fixed relation to the system clock, so it is resynchronised first. A falling edge on the synchronised line starts a short write sequence. The sequence places the upper byte of the sample on the SRAM pins, then the lower byte, and gives each byte its own write strobe.

Each half of the sample has its own address counter. Upper bytes fill one run of addresses and lower bytes fill another, and each counter wraps at the end of its range. The sample is captured when the sequence starts, so the ADC bus may move on to the next conversion while the two writes are still in progress. A busy output shows when the sequence is running. Conversion-done edges that arrive during that time are dropped.

Top module: `adc_byte_sram_writer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, sram_we_n is 1, busy is 0, sram_addr is 0 and sram_data is 0.
- R2: Only a falling edge (1 to 0) of conv_done starts a write sequence. A rising edge, or a level held low or high, starts nothing.
- R3: With default parameters, if the falling edge of conv_done is first seen low at clock edge n, the first byte's address and data appear on the pins after clock edge n+2 and busy rises at that same edge.
- R4: The upper byte, adc_sample[15:8], is written first, at the upper-byte counter's address. The lower byte, adc_sample[7:0], is written second, at the lower-byte counter's address.
- R5: For each byte, address and data are on the pins SETUP_CYCLES clocks before sram_we_n goes low (default 1). sram_we_n stays low for STROBE_CYCLES clocks (default 1). Address and data stay unchanged for HOLD_CYCLES clocks after sram_we_n returns high (default 1).
- R6: The lower byte's address and data are driven in the clock that immediately follows the upper byte's hold clock. With defaults, this puts the two strobes three clocks apart.
- R7: The upper-byte and lower-byte address counters each start at 0. Each advances by one after its own byte's hold period and wraps from 255 to 0.
- R8: The sample is captured on the clock that starts the sequence. Later changes on adc_sample do not alter either byte of that sequence.
- R9: busy is 1 for exactly 2*(SETUP_CYCLES+STROBE_CYCLES+HOLD_CYCLES) consecutive clocks per sequence (6 by default). sram_we_n is low only while busy is 1.
- R10: A falling edge of conv_done that is detected while a sequence is running is discarded and never produces a later sequence.
- R11: While idle, sram_we_n is 1, sram_data is 0 and sram_addr shows the address the next upper byte will use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_sample | input | 16 | Parallel ADC sample, upper byte in bits 15:8 |
| conv_done | input | 1 | Asynchronous conversion-done flag; a falling edge marks a new sample |
| sram_addr | output | 8 | SRAM address |
| sram_data | output | 8 | SRAM write data byte |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| busy | output | 1 | High while a two-byte write sequence runs |

## Verification
The assertions assume the design leaves reset in a quiet state and that conv_done changes slowly compared with the clock, so each level is held long enough for the two-flop synchroniser to see it. The bench drives conv_done and adc_sample only on the falling clock edge. This keeps the point at which the synchroniser samples each level deterministic, while conv_done is still treated as an unrelated signal. Every bench pulse stays low and high for at least one full cycle. adc_sample changes only when conv_done falls, or several clocks after the capture. The later case is the one used to show that a change in mid-sequence has no effect.

// File: rtl/adc_sram_writer_pkg.sv
package adc_sram_writer_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } wr_phase_e;

   typedef enum logic {
      LANE_UPPER = 1'b0,
      LANE_LOWER = 1'b1
   } byte_lane_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/conv_done_fall_sync.sv
module conv_done_fall_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic fall_pulse
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("conv_done_fall_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         last_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign fall_pulse = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/byte_addr_counter.sv
module byte_addr_counter #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   output logic [ADDR_W-1:0] count
);

   localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (advance) begin
         count <= (count == LAST) ? '0 : count + 1'b1;
      end
   end

endmodule

// File: rtl/byte_write_sequencer.sv
module byte_write_sequencer
   import adc_sram_writer_pkg::*;
#(
   parameter int unsigned BYTE_W        = 8,
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned SETUP_CYCLES  = 1,
   parameter int unsigned STROBE_CYCLES = 1,
   parameter int unsigned HOLD_CYCLES   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] upper_in,
   input  logic [BYTE_W-1:0] lower_in,
   input  logic [ADDR_W-1:0] upper_addr,
   input  logic [ADDR_W-1:0] lower_addr,
   output logic              upper_done,
   output logic              lower_done,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BYTE_W-1:0] data_o,
   output logic              we_n_o,
   output logic              busy_o
);

   localparam int unsigned LONGEST = max3(SETUP_CYCLES, STROBE_CYCLES, HOLD_CYCLES);
   localparam int unsigned TMR_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;
   localparam logic [TMR_W-1:0] SETUP_LAST  = TMR_W'(SETUP_CYCLES - 1);
   localparam logic [TMR_W-1:0] STROBE_LAST = TMR_W'(STROBE_CYCLES - 1);
   localparam logic [TMR_W-1:0] HOLD_LAST   = TMR_W'(HOLD_CYCLES - 1);

   generate
      if (SETUP_CYCLES < 1 || STROBE_CYCLES < 1 || HOLD_CYCLES < 1) begin : g_bad_timing
         $error("byte_write_sequencer: every phase needs at least one cycle");
      end
   endgenerate

   wr_phase_e   phase_q, phase_d;
   byte_lane_e  lane_q, lane_d;
   logic [TMR_W-1:0] tmr_q, tmr_d;
   logic [BYTE_W-1:0] upper_q, lower_q;
   logic        phase_end;
   logic        launch;
   logic [ADDR_W-1:0] addr_d;
   logic [BYTE_W-1:0] data_d;

   assign launch = (phase_q == PH_IDLE) && start;

   always_comb begin
      unique case (phase_q)
         PH_SETUP:  phase_end = (tmr_q == SETUP_LAST);
         PH_STROBE: phase_end = (tmr_q == STROBE_LAST);
         PH_HOLD:   phase_end = (tmr_q == HOLD_LAST);
         default:   phase_end = 1'b0;
      endcase
   end

   always_comb begin
      phase_d    = phase_q;
      lane_d     = lane_q;
      tmr_d      = tmr_q;
      upper_done = 1'b0;
      lower_done = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (start) begin
               phase_d = PH_SETUP;
               lane_d  = LANE_UPPER;
               tmr_d   = '0;
            end
         end
         PH_SETUP: begin
            if (phase_end) begin
               phase_d = PH_STROBE;
               tmr_d   = '0;
            end else begin
               tmr_d = tmr_q + 1'b1;
            end
         end
         PH_STROBE: begin
            if (phase_end) begin
               phase_d = PH_HOLD;
               tmr_d   = '0;
            end else begin
               tmr_d = tmr_q + 1'b1;
            end
         end
         PH_HOLD: begin
            if (phase_end) begin
               tmr_d = '0;
               if (lane_q == LANE_UPPER) begin
                  phase_d    = PH_SETUP;
                  lane_d     = LANE_LOWER;
                  upper_done = 1'b1;
               end else begin
                  phase_d    = PH_IDLE;
                  lane_d     = LANE_UPPER;
                  lower_done = 1'b1;
               end
            end else begin
               tmr_d = tmr_q + 1'b1;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_comb begin
      if (phase_d == PH_IDLE) begin
         addr_d = upper_addr;
         data_d = '0;
      end else if (lane_d == LANE_LOWER) begin
         addr_d = lower_addr;
         data_d = lower_q;
      end else begin
         addr_d = upper_addr;
         data_d = launch ? upper_in : upper_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         lane_q  <= LANE_UPPER;
         tmr_q   <= '0;
         upper_q <= '0;
         lower_q <= '0;
         addr_o  <= '0;
         data_o  <= '0;
         we_n_o  <= 1'b1;
         busy_o  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         lane_q  <= lane_d;
         tmr_q   <= tmr_d;
         if (launch) begin
            upper_q <= upper_in;
            lower_q <= lower_in;
         end
         addr_o <= addr_d;
         data_o <= data_d;
         we_n_o <= (phase_d != PH_STROBE);
         busy_o <= (phase_d != PH_IDLE);
      end
   end

endmodule

// File: rtl/adc_byte_sram_writer.sv
module adc_byte_sram_writer #(
   parameter int unsigned SAMPLE_W      = 16,
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned SETUP_CYCLES  = 1,
   parameter int unsigned STROBE_CYCLES = 1,
   parameter int unsigned HOLD_CYCLES   = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SAMPLE_W-1:0]   adc_sample,
   input  logic                  conv_done,
   output logic [ADDR_W-1:0]     sram_addr,
   output logic [SAMPLE_W/2-1:0] sram_data,
   output logic                  sram_we_n,
   output logic                  busy
);

   localparam int unsigned BYTE_W = SAMPLE_W / 2;
   localparam int unsigned LANES  = 2;

   generate
      if (SAMPLE_W != 2 * BYTE_W || BYTE_W < 1) begin : g_bad_width
         $error("adc_byte_sram_writer: SAMPLE_W must be an even number of bits");
      end
   endgenerate

   logic                start;
   logic [LANES-1:0]    lane_advance;
   logic [ADDR_W-1:0]   lane_addr [LANES];

   conv_done_fall_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_in  (conv_done),
      .fall_pulse(start)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane_cnt
         byte_addr_counter #(
            .ADDR_W(ADDR_W)
         ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .advance(lane_advance[g]),
            .count  (lane_addr[g])
         );
      end
   endgenerate

   byte_write_sequencer #(
      .BYTE_W       (BYTE_W),
      .ADDR_W       (ADDR_W),
      .SETUP_CYCLES (SETUP_CYCLES),
      .STROBE_CYCLES(STROBE_CYCLES),
      .HOLD_CYCLES  (HOLD_CYCLES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .upper_in  (adc_sample[SAMPLE_W-1:BYTE_W]),
      .lower_in  (adc_sample[BYTE_W-1:0]),
      .upper_addr(lane_addr[0]),
      .lower_addr(lane_addr[1]),
      .upper_done(lane_advance[0]),
      .lower_done(lane_advance[1]),
      .addr_o    (sram_addr),
      .data_o    (sram_data),
      .we_n_o    (sram_we_n),
      .busy_o    (busy)
   );

endmodule

// File: rtl/adc_byte_sram_writer_chk.sv
module adc_byte_sram_writer_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned SEQ_LEN  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] sram_addr,
   input logic [BYTE_W-1:0] sram_data,
   input logic              sram_we_n,
   input logic              busy
);

   logic [31:0] busy_run;
   logic [31:0] last_run;
   logic [2:0]  strobes;
   logic [2:0]  last_strobes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_run     <= '0;
         last_run     <= 32'(SEQ_LEN);
         strobes      <= '0;
         last_strobes <= 3'd2;
      end else if (busy) begin
         busy_run <= busy_run + 1;
         if (!sram_we_n && strobes != 3'd7) strobes <= strobes + 1'b1;
      end else begin
         if (busy_run != 0) begin
            last_run     <= busy_run;
            last_strobes <= strobes;
         end
         busy_run <= '0;
         strobes  <= '0;
      end
   end

   AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> busy) else $error("strobe outside busy"); // R9

   AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_data))) else $error("setup"); // R5

   AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_data))) else $error("hold"); // R5

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sram_we_n && sram_data == '0)) else $error("idle pins"); // R11

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      last_run == 32'(SEQ_LEN)) else $error("busy run length"); // R9

   AST_TWO_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      last_strobes == 3'd2) else $error("strobe count"); // R4

endmodule

bind adc_byte_sram_writer adc_byte_sram_writer_chk #(
   .ADDR_W (ADDR_W),
   .BYTE_W (SAMPLE_W / 2),
   .SEQ_LEN(2 * (SETUP_CYCLES + STROBE_CYCLES + HOLD_CYCLES))
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sram_addr(sram_addr),
   .sram_data(sram_data),
   .sram_we_n(sram_we_n),
   .busy     (busy)
);

// File: tb/adc_byte_sram_writer_tb.sv
module adc_byte_sram_writer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] adc_sample = 16'h0000;
   logic        conv_done = 1'b1;
   logic [7:0]  sram_addr;
   logic [7:0]  sram_data;
   logic        sram_we_n;
   logic        busy;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   adc_byte_sram_writer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .adc_sample(adc_sample),
      .conv_done (conv_done),
      .sram_addr (sram_addr),
      .sram_data (sram_data),
      .sram_we_n (sram_we_n),
      .busy      (busy)
   );

   // reference model: expected {busy, we_n, addr, data} per cycle
   logic [17:0] pend[$];
   logic [17:0] cur;
   logic [7:0]  m_hi = 8'd0;
   logic [7:0]  m_lo = 8'd0;
   logic        d1 = 1'b1, d2 = 1'b1;

   function automatic logic [17:0] ent(input logic b, input logic w,
                                        input logic [7:0] a, input logic [7:0] d);
      return {b, w, a, d};
   endfunction

   initial cur = ent(1'b0, 1'b1, 8'd0, 8'd0);

   always @(posedge clk) begin
      if (!rst_n) begin
         pend.delete();
         m_hi = 8'd0;
         m_lo = 8'd0;
         d1 = 1'b1;
         d2 = 1'b1;
         cur = ent(1'b0, 1'b1, 8'd0, 8'd0);
      end else begin
         logic fall_seen;
         fall_seen = d2 & ~d1;
         if (pend.size() > 0) cur = pend.pop_front();
         else cur = ent(1'b0, 1'b1, m_hi, 8'd0);
         if (cur[17] == 1'b0 && fall_seen) begin
            pend.push_back(ent(1'b1, 1'b1, m_hi, adc_sample[15:8]));
            pend.push_back(ent(1'b1, 1'b0, m_hi, adc_sample[15:8]));
            pend.push_back(ent(1'b1, 1'b1, m_hi, adc_sample[15:8]));
            pend.push_back(ent(1'b1, 1'b1, m_lo, adc_sample[7:0]));
            pend.push_back(ent(1'b1, 1'b0, m_lo, adc_sample[7:0]));
            pend.push_back(ent(1'b1, 1'b1, m_lo, adc_sample[7:0]));
            m_hi = m_hi + 8'd1;
            m_lo = m_lo + 8'd1;
         end
         d2 = d1;
         d1 = conv_done;
      end
   end

   task automatic check(input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (cur[17]) begin
            check("R4 R7", "sram_addr", int'(sram_addr), int'(cur[15:8]));
            check("R4 R8", "sram_data", int'(sram_data), int'(cur[7:0]));
            check("R5 R6", "sram_we_n", int'(sram_we_n), int'(cur[16]));
            check("R9 R3", "busy", int'(busy), 1);
         end else begin
            check("R11 R2 R10", "sram_addr", int'(sram_addr), int'(cur[15:8]));
            check("R11", "sram_data", int'(sram_data), 0);
            check("R11", "sram_we_n", int'(sram_we_n), 1);
            check("R2 R10", "busy", int'(busy), 0);
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   task automatic pulse(input logic [15:0] d, input int low, input int gap);
      @(negedge clk);
      adc_sample = d;
      conv_done  = 1'b0;
      repeat (low) @(negedge clk);
      conv_done = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset values while in reset
      check("R1", "reset we_n", int'(sram_we_n), 1);
      check("R1", "reset busy", int'(busy), 0);
      check("R1", "reset addr", int'(sram_addr), 0);
      check("R1", "reset data", int'(sram_data), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R3: latency of first byte after a falling edge
      @(negedge clk);
      adc_sample = 16'hA5C3;
      conv_done  = 1'b0;
      @(negedge clk);              // edge n sampled low
      @(negedge clk);              // after n+1
      check("R3", "no early busy", int'(busy), 0);
      @(negedge clk);              // after n+2
      check("R3", "busy at n+2", int'(busy), 1);
      check("R3", "upper byte first", int'(sram_data), 16'hA5);
      repeat (10) @(negedge clk);

      // R2: rising edge alone starts nothing (conv_done still low here)
      conv_done = 1'b1;
      repeat (10) @(negedge clk);
      check("R2", "rising edge ignored", int'(busy), 0);

      // R10: second fall during busy is dropped
      pulse(16'h1234, 2, 1);
      conv_done = 1'b0;
      @(negedge clk);
      conv_done = 1'b1;
      repeat (12) @(negedge clk);

      // R8: bus changes mid-sequence
      @(negedge clk);
      adc_sample = 16'hBEEF;
      conv_done  = 1'b0;
      repeat (4) @(negedge clk);
      adc_sample = 16'h0000;
      repeat (2) @(negedge clk);
      adc_sample = 16'hFFFF;
      conv_done  = 1'b1;
      repeat (8) @(negedge clk);

      // back-to-back restart right when idle
      pulse(16'h8001, 1, 6);
      pulse(16'h7F80, 1, 6);

      // R7: run both counters through wrap
      for (int i = 0; i < 258; i++) begin
         pulse(16'(i * 16'h0107 + 16'h3C5A), 1, 8);
      end
      repeat (10) @(negedge clk);
      check("R7", "final idle addr", int'(sram_addr), int'(m_hi));

      done = 1'b1;
      summary();
      $finish;
   end

endmodule